// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is a bus master that stores a block of one to sixteen bytes into a byte-wide parallel EEPROM using a single page write. A client pulses a start request with a base address and a byte count. The controller first pulls every byte from a request/valid data port into a local buffer. It then issues one write-enable-controlled load cycle per byte. All loads of the block stay inside one 16-byte page. Every setup, hold and pulse-width limit of the memory is counted in clock cycles set by parameters.

The memory starts programming on its own when no new write strobe arrives within its byte-load window. The controller therefore emits the loads back to back at a fixed cadence well inside that window. After the final load it releases the data bus. It then issues ordinary read cycles at the last written address. The memory returns the inverse of the written bit 7 while it is still programming. When the true bit 7 is read back, the controller pulses `done_o`. If the true value has not appeared within a cycle budget, it pulses `err_o` instead.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, and whenever no operation is running, the chip-enable, output-enable and write-enable strobes are high (inactive), the data-bus output enable is low, and `busy_o` and `req_o` are low.
- R2: A start request whose count is 0 or greater than 16 is ignored: `busy_o` and `req_o` stay low.
- R3: Bytes are requested by index 0, 1, ..., count-1 in that order. Each index is held on `req_idx_o` with `req_o` high until a cycle with `dat_valid_i` high. All bytes are fetched before the first write strobe.
- R4: Byte i is loaded at address {base[10:4], (base[3:0] + i) mod 16}, so every load of one operation carries the same upper seven address bits. Exactly count loads are made.
- R5: Write enable stays low for at least WE_LOW_CYC cycles per load. It stays high for at least WE_HIGH_CYC cycles between loads. Address and write data do not change while it is low, and the address is still the same in the cycle it rises.
- R6: Consecutive falling edges of write enable within one operation are less than BLC_CYC cycles apart.
- R7: Output enable is high whenever write enable is low. The controller never drives the data bus while output enable is low.
- R8: After the last load, the controller reads the last written address with chip enable and output enable low and write enable high. It pulses `done_o` for one cycle only after a read whose bit 7 equals the written bit 7. `busy_o` is low after that pulse.
- R9: If no matching read occurs within POLL_LIMIT cycles of the end of the last load, `err_o` pulses for one cycle instead of `done_o`, and the controller returns to idle.
- R10: A start request while `busy_o` is high has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| base_addr_i | input | 11 | Base address of the block |
| count_i | input | 5 | Number of bytes, 1 to 16 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: programming confirmed |
| err_o | output | 1 | One-cycle pulse: poll budget exhausted |
| req_o | output | 1 | Byte request to the data source |
| req_idx_o | output | 4 | Index of the requested byte |
| dat_valid_i | input | 1 | Requested byte is present on dat_i |
| dat_i | input | 8 | Byte from the data source |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_addr_o | output | 11 | Memory address bus |
| mem_dq_o | output | 8 | Data bus value driven by the controller |
| mem_dq_oe_o | output | 1 | Controller drives the data bus when high |
| mem_dq_i | input | 8 | Data bus value read from the memory |

## Verification
The bench attaches a memory model that latches the address at each write-enable fall and the data at each rise. The model starts programming only after its load window runs out, and it inverts bit 7 of the last written address until it commits. Blocks that wrap inside a page, blocks at the page edge, single bytes and random lengths with random source latency show whether the address arithmetic, the load count and the fetch order are right. Random programming times show whether the controller finishes only after the commit, rather than after a fixed delay. A model that never commits separates a correct timeout from a hang or a false completion. Bad counts and a start that arrives mid-operation show that such requests change nothing.

// File: rtl/eew_pkg.sv
package eew_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WSET,
    ST_WLOW,
    ST_WHIGH,
    ST_PTURN,
    ST_PREAD,
    ST_PGAP,
    ST_DONE,
    ST_ERR
  } eew_state_e;

  // larger of two cycle counts
  function automatic int eew_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold the value v
  function automatic int eew_bits_for(input int v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/eew_phase_timer.sv
module eew_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_m1_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= len_m1_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = (cnt_q == '0);

  // a phase loaded with more than one cycle cannot end on the next cycle
  a_r5_phase_length: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && (len_m1_i != '0) |=> !expire_o);

endmodule

// File: rtl/eew_fetch_buf.sv
module eew_fetch_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              dat_valid_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic              fill_done_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] store [DEPTH];
  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;
  logic              at_last;

  assign take    = active_q && dat_valid_i;
  assign at_last = (CNT_W'(idx_q) == cnt_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      idx_q       <= '0;
      cnt_q       <= '0;
      fill_done_o <= 1'b0;
    end else begin
      fill_done_o <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        cnt_q    <= cnt_i;
      end else if (take) begin
        if (at_last) begin
          active_q    <= 1'b0;
          fill_done_o <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) store[idx_q] <= dat_i;
  end

  assign req_o     = active_q;
  assign req_idx_o = idx_q;
  assign rd_data_o = store[rd_idx_i];

  // R3: an accepted byte either ends the fetch or advances the index by one
  a_r3_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && dat_valid_i && !go_i |=> fill_done_o || (req_idx_o == $past(req_idx_o) + IDX_W'(1)));

  // R3: the request is held, with its index, until the byte arrives
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !dat_valid_i && !go_i |=> req_o && $stable(req_idx_o));

endmodule

// File: rtl/eew_poll_watch.sv
module eew_poll_watch #(
  parameter int LIMIT = 1000,
  parameter int W     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run_i)                 cnt_q <= '0;
    else if (cnt_q < W'(LIMIT))      cnt_q <= cnt_q + W'(1);
  end

  assign expired_o = (cnt_q >= W'(LIMIT));

  // R9: leaving the poll phase clears the budget
  a_r9_budget_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !expired_o);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eew_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int SETUP_CYC   = 2,
  parameter int WE_LOW_CYC  = 10,
  parameter int WE_HIGH_CYC = 7,
  parameter int TURN_CYC    = 2,
  parameter int READ_CYC    = 25,
  parameter int GAP_CYC     = 2,
  parameter int BLC_CYC     = 2500,
  parameter int POLL_LIMIT  = 1250000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic [ADDR_W-1:0]                     base_addr_i,
  input  logic [$clog2(PAGE_BYTES+1)-1:0]       count_i,
  output logic                                  busy_o,
  output logic                                  done_o,
  output logic                                  err_o,
  output logic                                  req_o,
  output logic [$clog2(PAGE_BYTES)-1:0]         req_idx_o,
  input  logic                                  dat_valid_i,
  input  logic [DATA_W-1:0]                     dat_i,
  output logic                                  mem_ce_n_o,
  output logic                                  mem_oe_n_o,
  output logic                                  mem_we_n_o,
  output logic [ADDR_W-1:0]                     mem_addr_o,
  output logic [DATA_W-1:0]                     mem_dq_o,
  output logic                                  mem_dq_oe_o,
  input  logic [DATA_W-1:0]                     mem_dq_i
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
  localparam int TMAX   = eew_max(eew_max(eew_max(SETUP_CYC, WE_LOW_CYC), eew_max(WE_HIGH_CYC, TURN_CYC)),
                                  eew_max(READ_CYC, GAP_CYC));
  localparam int TMR_W  = eew_bits_for(TMAX);
  localparam int PW     = eew_bits_for(POLL_LIMIT);
  localparam logic [TMR_W-1:0] LEN_SET  = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] LEN_LOW  = TMR_W'(WE_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] LEN_HIGH = TMR_W'(WE_HIGH_CYC - 1);
  localparam logic [TMR_W-1:0] LEN_TURN = TMR_W'(TURN_CYC - 1);
  localparam logic [TMR_W-1:0] LEN_READ = TMR_W'(READ_CYC - 1);
  localparam logic [TMR_W-1:0] LEN_GAP  = TMR_W'(GAP_CYC - 1);

  // address of byte i: page bits from the base, offset wraps inside the page
  function automatic logic [ADDR_W-1:0] byte_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0]  i);
    logic [IDX_W-1:0] off;
    off = b[IDX_W-1:0] + i;
    return {b[ADDR_W-1:IDX_W], off};
  endfunction

  // a count is accepted when it is 1..PAGE_BYTES
  function automatic logic count_ok(input logic [CNT_W-1:0] c);
    return (c != '0) && (c <= CNT_W'(PAGE_BYTES));
  endfunction

  eew_state_e        state, state_n;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  bidx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_q;

  // named internal events
  logic              ev_go;
  logic              ev_first;
  logic              ev_advance;
  logic              ev_capture;
  logic              ev_fill_done;
  logic              ev_last_byte;
  logic              ev_match;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_len;
  logic              tmr_exp;
  logic              poll_run;
  logic              poll_exp;
  logic [DATA_W-1:0] buf_data;

  assign ev_last_byte = (CNT_W'(bidx_q) == cnt_q - CNT_W'(1));
  assign ev_match     = (rd_q[DATA_W-1] == buf_data[DATA_W-1]);
  assign poll_run     = (state == ST_PTURN) || (state == ST_PREAD) || (state == ST_PGAP);

  eew_fetch_buf #(
    .DATA_W (DATA_W),
    .DEPTH  (PAGE_BYTES),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (ev_go),
    .cnt_i       (count_i),
    .dat_valid_i (dat_valid_i),
    .dat_i       (dat_i),
    .req_o       (req_o),
    .req_idx_o   (req_idx_o),
    .fill_done_o (ev_fill_done),
    .rd_idx_i    (bidx_q),
    .rd_data_o   (buf_data)
  );

  eew_phase_timer #(
    .W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .len_m1_i (tmr_len),
    .expire_o (tmr_exp)
  );

  eew_poll_watch #(
    .LIMIT (POLL_LIMIT),
    .W     (PW)
  ) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (poll_run),
    .expired_o (poll_exp)
  );

  always_comb begin
    state_n    = state;
    tmr_load   = 1'b0;
    tmr_len    = '0;
    ev_go      = 1'b0;
    ev_first   = 1'b0;
    ev_advance = 1'b0;
    ev_capture = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start_i && count_ok(count_i)) begin
          ev_go   = 1'b1;
          state_n = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (ev_fill_done) begin
          ev_first = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = LEN_SET;
          state_n  = ST_WSET;
        end
      end
      ST_WSET: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = LEN_LOW;
          state_n  = ST_WLOW;
        end
      end
      ST_WLOW: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = LEN_HIGH;
          state_n  = ST_WHIGH;
        end
      end
      ST_WHIGH: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (ev_last_byte) begin
            tmr_len = LEN_TURN;
            state_n = ST_PTURN;
          end else begin
            ev_advance = 1'b1;
            tmr_len    = LEN_SET;
            state_n    = ST_WSET;
          end
        end
      end
      ST_PTURN: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = LEN_READ;
          state_n  = ST_PREAD;
        end
      end
      ST_PREAD: begin
        if (tmr_exp) begin
          ev_capture = 1'b1;
          tmr_load   = 1'b1;
          tmr_len    = LEN_GAP;
          state_n    = ST_PGAP;
        end
      end
      ST_PGAP: begin
        if (tmr_exp) begin
          if (ev_match) begin
            state_n = ST_DONE;
          end else if (poll_exp) begin
            state_n = ST_ERR;
          end else begin
            tmr_load = 1'b1;
            tmr_len  = LEN_READ;
            state_n  = ST_PREAD;
          end
        end
      end
      ST_DONE: state_n = ST_IDLE;
      ST_ERR:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      bidx_q <= '0;
      addr_q <= '0;
      rd_q   <= '0;
    end else begin
      state <= state_n;
      if (ev_go) begin
        base_q <= base_addr_i;
        cnt_q  <= count_i;
      end
      if (ev_first) begin
        bidx_q <= '0;
        addr_q <= byte_addr(base_q, '0);
      end
      if (ev_advance) begin
        bidx_q <= bidx_q + IDX_W'(1);
        addr_q <= byte_addr(base_q, bidx_q + IDX_W'(1));
      end
      if (ev_capture) rd_q <= mem_dq_i;
    end
  end

  // strobe decode
  assign mem_ce_n_o  = !((state == ST_WSET) || (state == ST_WLOW) || (state == ST_WHIGH) ||
                         (state == ST_PREAD));
  assign mem_we_n_o  = (state != ST_WLOW);
  assign mem_oe_n_o  = (state != ST_PREAD);
  assign mem_dq_oe_o = (state == ST_WSET) || (state == ST_WLOW) || (state == ST_WHIGH);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = buf_data;
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);
  assign err_o       = (state == ST_ERR);

  // ---------------------------------------------------------------
  // checker support: strobe run lengths and load spacing
  // ---------------------------------------------------------------
  int unsigned low_run_q, high_run_q, fall_gap_q;
  logic        had_fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= 0;
      high_run_q <= 0;
      fall_gap_q <= 0;
      had_fall_q <= 1'b0;
    end else begin
      low_run_q  <= mem_we_n_o ? 0 : low_run_q + 1;
      high_run_q <= mem_we_n_o ? high_run_q + 1 : 0;
      if (!busy_o) begin
        had_fall_q <= 1'b0;
        fall_gap_q <= 0;
      end else if (!mem_we_n_o && (low_run_q == 0)) begin
        had_fall_q <= 1'b1;
        fall_gap_q <= 1;
      end else if (fall_gap_q < BLC_CYC + 1) begin
        fall_gap_q <= fall_gap_q + 1;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o && !req_o);

  a_r2_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && !count_ok(count_i) |=> !busy_o);

  a_r4_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> mem_addr_o[ADDR_W-1:IDX_W] == base_q[ADDR_W-1:IDX_W]);

  a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> low_run_q >= WE_LOW_CYC);

  a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n_o) && had_fall_q |-> high_run_q >= WE_HIGH_CYC);

  a_r5_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o && $past(!mem_we_n_o) |-> $stable(mem_addr_o) && $stable(mem_dq_o));

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> $stable(mem_addr_o));

  a_r6_load_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n_o) && had_fall_q |-> fall_gap_q < BLC_CYC);

  a_r7_oe_high_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> mem_oe_n_o);

  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> !mem_dq_oe_o);

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o}));

  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done_o || err_o |=> !busy_o);

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o && !err_o |=> busy_o && $stable(base_q) && $stable(cnt_q));

endmodule

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;
  localparam int BLC   = 300;
  localparam int PLIM  = 1200;
  localparam int WLOW  = 10;
  localparam int WHIGH = 7;
  localparam int RDC   = 25;
  localparam int GAPC  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] base_addr_i = '0;
  logic [4:0]  count_i = '0;
  logic        busy_o, done_o, err_o, req_o;
  logic [3:0]  req_idx_o;
  logic        dat_valid_i = 1'b0;
  logic [7:0]  dat_i = '0;
  logic        mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o;
  logic [10:0] mem_addr_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  always #4 clk = ~clk;

  eeprom_page_writer #(.BLC_CYC(BLC), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .count_i(count_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .req_o(req_o), .req_idx_o(req_idx_o), .dat_valid_i(dat_valid_i), .dat_i(dat_i),
    .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_dq_i)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] ref_mem [2048];
  logic [7:0] exp_bytes [16];
  logic [6:0] exp_page;
  int op_seq = 0;
  int prog_len_tb = 100;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_addr(input logic [10:0] b, input int i);
    int off;
    off = (int'(b) + i) % 16;
    return (b & 11'h7F0) | 11'(off);
  endfunction

  // ---------------- data source ----------------
  int fetched = 0;
  int src_seen = 0;
  int src_wait = 0;
  always @(negedge clk) begin
    if (src_seen != op_seq) begin src_seen = op_seq; fetched = 0; end
    if (dat_valid_i) begin
      dat_valid_i <= 1'b0;
    end else if (req_o) begin
      if (src_wait == 0) begin
        dat_valid_i <= 1'b1;
        dat_i <= exp_bytes[req_idx_o];
        fetched = fetched + 1;
        src_wait = int'($urandom % 4);
      end else src_wait = src_wait - 1;
    end
  end

  // ---------------- memory model ----------------
  logic [7:0]  mem [2048];
  logic [10:0] pend_a [16];
  logic [7:0]  pend_d [16];
  int pn, loads, page_bad, stable_bad, oe_bad, cont_bad, ce_bad, poll_reads;
  int low_run, high_run, min_low, min_high, gap, max_gap, fetch_first;
  int win, prog_cnt, commit_cyc, cyc, seen_seq;
  bit loading, programming, committed, prev_we;
  logic [10:0] fall_addr, last_addr;
  logic [7:0]  last_data, prev_dq;

  task automatic model_clear();
    pn = 0; loads = 0; page_bad = 0; stable_bad = 0; oe_bad = 0; cont_bad = 0; ce_bad = 0;
    poll_reads = 0; min_low = 1000; min_high = 1000; max_gap = 0; gap = 0; fetch_first = -1;
    loading = 0; programming = 0; committed = 0; win = 0; prog_cnt = 0; commit_cyc = 0;
  endtask

  initial begin
    cyc = 0; seen_seq = 0; prev_we = 1; low_run = 0; high_run = 0;
    last_addr = '0; last_data = '0; fall_addr = '0; prev_dq = '0;
    model_clear();
    for (int a = 0; a < 2048; a++) begin
      mem[a] = 8'(a) ^ 8'h5A;
      ref_mem[a] = 8'(a) ^ 8'h5A;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (seen_seq != op_seq) begin seen_seq = op_seq; model_clear(); end
    if (rst_n) begin
      if (!mem_we_n_o && !mem_oe_n_o) oe_bad++;
      if (mem_dq_oe_o && !mem_oe_n_o) cont_bad++;
      if (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o) poll_reads++;
      if (prev_we && !mem_we_n_o) begin
        if (loads > 0) begin
          if (high_run < min_high) min_high = high_run;
          if (gap > max_gap) max_gap = gap;
        end else fetch_first = fetched;
        if (mem_ce_n_o) ce_bad++;
        if (mem_addr_o[10:4] != exp_page) page_bad++;
        fall_addr = mem_addr_o;
        loads++; loading = 1; win = 0; gap = 0; low_run = 0;
      end
      if (!prev_we && mem_we_n_o) begin
        if (low_run < min_low) min_low = low_run;
        if (mem_addr_o != fall_addr || !mem_dq_oe_o) stable_bad++;
        if (pn < 16) begin pend_a[pn] = fall_addr; pend_d[pn] = mem_dq_o; pn++; end
        last_addr = fall_addr; last_data = mem_dq_o; high_run = 0;
      end
      if (!prev_we && !mem_we_n_o && mem_dq_o != prev_dq) stable_bad++;
      if (!mem_we_n_o) low_run++; else high_run++;
      gap++;
      if (loading) begin
        win++;
        if (win >= BLC && mem_we_n_o) begin loading = 0; programming = 1; prog_cnt = prog_len_tb; end
      end else if (programming) begin
        if (prog_cnt == 0) begin
          for (int k = 0; k < pn; k++) mem[pend_a[k]] = pend_d[k];
          programming = 0; committed = 1; commit_cyc = cyc;
        end else prog_cnt--;
      end
      prev_we = mem_we_n_o; prev_dq = mem_dq_o;
    end
  end

  always @* begin
    if (!mem_ce_n_o && !mem_oe_n_o) begin
      if ((loading || programming) && mem_addr_o == last_addr)
        mem_dq_i = {~last_data[7], last_data[6:0]};
      else
        mem_dq_i = mem[mem_addr_o];
    end else mem_dq_i = 8'hFF;
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", wd);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- operations ----------------
  task automatic run_op(input logic [10:0] b, input int n, input int prog, input bit want_err, input bit inject);
    int t;
    bit got_done, got_err;
    for (int i = 0; i < 16; i++) exp_bytes[i] = 8'($urandom);
    exp_page = b[10:4];
    prog_len_tb = prog;
    op_seq++;
    @(negedge clk);
    start_i = 1'b1; base_addr_i = b; count_i = 5'(n);
    @(negedge clk);
    start_i = 1'b0;
    t = 0; got_done = 0; got_err = 0;
    while (!got_done && !got_err && t < 20000) begin
      @(negedge clk);
      t++;
      if (done_o) got_done = 1;
      if (err_o) got_err = 1;
      if (inject && t == 40) begin start_i = 1'b1; base_addr_i = ~b; count_i = 5'd5; end
      else if (inject && t == 41) start_i = 1'b0;
      if (got_done) begin
        chk(committed, "R8", "done before memory committed", int'(committed), 1);
        chk(cyc - commit_cyc <= 2 * (RDC + GAPC) + 6, "R8", "done latency after commit",
            cyc - commit_cyc, 2 * (RDC + GAPC) + 6);
      end
    end
    @(negedge clk);
    chk(!busy_o, "R8", "busy after end", int'(busy_o), 0);
    chk(loads == n, "R4", "load count", loads, n);
    chk(fetch_first == n, "R3", "bytes fetched at first strobe", fetch_first, n);
    chk(page_bad == 0 && ce_bad == 0, "R4", "loads outside page", page_bad + ce_bad, 0);
    chk(min_low >= WLOW, "R5", "min write-enable low", min_low, WLOW);
    if (n > 1) chk(min_high >= WHIGH, "R5", "min write-enable high", min_high, WHIGH);
    chk(stable_bad == 0, "R5", "addr/data moved while strobed", stable_bad, 0);
    chk(max_gap < BLC, "R6", "strobe spacing", max_gap, BLC - 1);
    chk(oe_bad == 0 && cont_bad == 0, "R7", "oe/bus conflicts", oe_bad + cont_bad, 0);
    chk(poll_reads > 0, "R8", "poll reads seen", poll_reads, 1);
    if (want_err) begin
      chk(got_err && !got_done, "R9", "timeout outcome err", int'(got_err), 1);
    end else begin
      chk(got_done && !got_err, "R8", "completion outcome done", int'(got_done), 1);
      for (int i = 0; i < n; i++) ref_mem[exp_addr(b, i)] = exp_bytes[i];
      for (int i = 0; i < 16; i++) begin
        logic [10:0] a;
        a = (b & 11'h7F0) | 11'(i);
        chk(mem[a] == ref_mem[a], inject ? "R10" : "R4", "page byte", int'(mem[a]), int'(ref_mem[a]));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(mem_ce_n_o && mem_oe_n_o && mem_we_n_o, "R1", "strobes in reset",
        {mem_ce_n_o, mem_oe_n_o, mem_we_n_o}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_dq_oe_o && !busy_o && !req_o && !done_o && !err_o, "R1", "idle outputs",
        {mem_dq_oe_o, busy_o, req_o, done_o, err_o}, 0);

    // R2: bad counts are ignored
    for (int k = 0; k < 2; k++) begin
      bit moved;
      moved = 0;
      start_i = 1'b1; base_addr_i = 11'h230; count_i = (k == 0) ? 5'd0 : 5'd17;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (busy_o || req_o || !mem_we_n_o || !mem_ce_n_o) moved = 1;
      end
      chk(!moved, "R2", "bad count started", int'(moved), 0);
    end

    run_op(11'h7F3, 16, 200, 0, 0);   // wrap inside the top page
    run_op(11'h000, 1, 60, 0, 0);     // single byte
    run_op(11'h125, 16, 450, 0, 0);
    run_op(11'h3A0, 7, 120, 0, 1);    // R10: start while busy
    for (int r = 0; r < 6; r++)
      run_op(11'($urandom), 1 + int'($urandom % 16), 50 + int'($urandom % 450), 0, 0);
    run_op(11'h555, 4, 1000000, 1, 0); // R9: never completes
    run_op(11'h0F8, 9, 80, 0, 0);     // recovery after timeout

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule